// File: doc/BRIEF.md
# Eleven-Way Selectable Integer ALU

This block is a pipelined 32-bit integer execution unit for a compute array that runs short generated programs of random integer math. Each cycle it may accept two operands and a 32-bit selector word. The selector is reduced modulo eleven, and the residue picks one of eleven operations: wrapping add, low or high half of the unsigned product, unsigned minimum, left or right rotation, the three bitwise logic operations, the sum of both operands' leading-zero counts, or the sum of both operands' set-bit counts.

The unit has no back-pressure. An input valid bit qualifies each issue, and the matching output valid bit comes back exactly two clock edges later with the result, in issue order. The multiplier is split over the two cycles. Both rotations are also done on the multiplier: the first operand is multiplied by a power of two, and the two halves of the product are ORed together. Operations that do not use the multiplier are computed in the first cycle and held one stage, so that every operation has the same latency.

Top module: `eleven_op_alu`

## Requirements
- R1: The operation is selected by `sel` mod 11, with residues 0 add, 1 multiply-low, 2 multiply-high, 3 unsigned min, 4 rotate-left, 5 rotate-right, 6 AND, 7 OR, 8 XOR, 9 leading-zero sum, 10 set-bit sum; the full 32-bit selector value is used.
- R2: Residue 0 returns (a+b) mod 2^32, and residues 6, 7 and 8 return a&b, a|b and a^b.
- R3: Residue 1 returns the low 32 bits of the unsigned product a*b.
- R4: Residue 2 returns the upper 32 bits of the 64-bit unsigned product a*b.
- R5: Residue 3 returns the smaller of a and b, with both compared as unsigned.
- R6: Residue 4 rotates a left by n = b mod 32, and n = 0 returns a unchanged (0x12345678 rotated by 8 gives 0x34567812).
- R7: Residue 5 rotates a right by n = b mod 32, which equals a left rotation by (32-n) mod 32.
- R8: Residue 9 returns clz(a)+clz(b), where clz of zero is 32, so two zero operands give 64.
- R9: Residue 10 returns popcount(a)+popcount(b).
- R10: `out_valid` is `in_valid` delayed by exactly two rising edges for every operation, and results leave in issue order.
- R11: While reset is held and after it is released, `out_valid` and `result` are 0 until the first issued operation reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue qualifier for the operands and selector |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; its low five bits give the rotate amount |
| sel | input | 32 | Selector word, reduced modulo 11 |
| out_valid | output | 1 | Result qualifier, two cycles after issue |
| result | output | 32 | Selected operation result |

## Verification
Every result is due two rising edges after the edge that captured its operands. The bench therefore drives inputs on the falling edge and keeps a two-entry history of expected values. At each falling edge it compares the outputs with the entry issued two falling edges earlier, before it drives the next issue, and it checks `out_valid` on every cycle, including idle gaps, so that an early, late or reordered result shows as a mismatch. Rotations by 0, 31 and 32, zero operands for the leading-zero sum, all-ones products and the largest selector values are issued directly, alongside seeded random traffic over all eleven residues.

// File: rtl/alu11_pkg.sv
package alu11_pkg;
  localparam int ALU_W   = 32;
  localparam int NUM_OPS = 11;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_MULL = 4'd1,
    OP_MULH = 4'd2,
    OP_MIN  = 4'd3,
    OP_ROTL = 4'd4,
    OP_ROTR = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CLZ  = 4'd9,
    OP_POP  = 4'd10
  } op_e;

  function automatic logic is_rot(op_e op);
    return (op == OP_ROTL) || (op == OP_ROTR);
  endfunction
endpackage

// File: rtl/alu11_decode.sv
module alu11_decode
  import alu11_pkg::*;
#(
  parameter int W = ALU_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] op_b,
  output op_e          op_idx,
  output logic [W-1:0] mul_rhs
);
  localparam int SH_W = $clog2(W);

  function automatic op_e reduce_sel(logic [W-1:0] s);
    logic [W-1:0] r;
    r = s % W'(NUM_OPS);
    return op_e'(r[3:0]);
  endfunction

  function automatic logic [SH_W-1:0] left_amount(op_e op, logic [W-1:0] b);
    logic [SH_W-1:0] n;
    n = b[SH_W-1:0];
    return (op == OP_ROTR) ? (SH_W'(0) - n) : n;
  endfunction

  logic [SH_W-1:0] rot_amt;

  always_comb begin
    op_idx  = reduce_sel(sel);
    rot_amt = left_amount(op_idx, op_b);
    mul_rhs = is_rot(op_idx) ? (W'(1) << rot_amt) : op_b;
  end

  // R1
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (op_idx < op_e'(NUM_OPS)));

  // R6
  rot_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_rot(op_idx)) |-> ($countones(mul_rhs) == 1));
endmodule

// File: rtl/alu11_simple.sv
module alu11_simple
  import alu11_pkg::*;
#(
  parameter int W = ALU_W
) (
  input  op_e          op_idx,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] simple_res
);
  localparam int CNT_W = $clog2(2 * W + 1);

  function automatic logic [CNT_W-1:0] lead_zeros(logic [W-1:0] v);
    logic [CNT_W-1:0] n;
    logic             seen;
    n    = '0;
    seen = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] ones(logic [W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  always_comb begin
    unique case (op_idx)
      OP_ADD:  simple_res = op_a + op_b;
      OP_MIN:  simple_res = (op_a < op_b) ? op_a : op_b;
      OP_AND:  simple_res = op_a & op_b;
      OP_OR:   simple_res = op_a | op_b;
      OP_XOR:  simple_res = op_a ^ op_b;
      OP_CLZ:  simple_res = W'(lead_zeros(op_a) + lead_zeros(op_b));
      OP_POP:  simple_res = W'(ones(op_a) + ones(op_b));
      default: simple_res = '0;
    endcase
  end
endmodule

// File: rtl/alu11_mul2.sv
module alu11_mul2 #(
  parameter int W = alu11_pkg::ALU_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [W-1:0]   lhs,
  input  logic [W-1:0]   rhs,
  output logic [2*W-1:0] prod
);
  localparam int HALF = W / 2;
  localparam int PP_W = W + HALF;

  logic [PP_W-1:0] pp_lo_d, pp_hi_d, pp_lo_q, pp_hi_q;

  assign pp_lo_d = PP_W'(lhs) * PP_W'(rhs[HALF-1:0]);
  assign pp_hi_d = PP_W'(lhs) * PP_W'(rhs[W-1:HALF]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pp_lo_q <= '0;
      pp_hi_q <= '0;
    end else if (en) begin
      pp_lo_q <= pp_lo_d;
      pp_hi_q <= pp_hi_d;
    end
  end

  assign prod = (2*W)'(pp_lo_q) + ((2*W)'(pp_hi_q) << HALF);
endmodule

// File: rtl/eleven_op_alu.sv
module eleven_op_alu
  import alu11_pkg::*;
#(
  parameter int W = ALU_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  op_a,
  input  logic [31:0]  op_b,
  input  logic [31:0]  sel,
  output logic         out_valid,
  output logic [31:0]  result
);
  op_e          op_idx;
  logic [W-1:0] mul_rhs;
  logic [W-1:0] simple_res;

  logic           s1_valid;
  op_e            s1_op;
  logic [W-1:0]   s1_simple;
  logic [2*W-1:0] s1_prod;
  logic [W-1:0]   prod_lo, prod_hi;
  logic [W-1:0]   s2_pick;

  alu11_decode #(.W(W)) u_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .sel(sel), .op_b(op_b), .op_idx(op_idx), .mul_rhs(mul_rhs)
  );

  alu11_simple #(.W(W)) u_simple (
    .op_idx(op_idx), .op_a(op_a), .op_b(op_b), .simple_res(simple_res)
  );

  alu11_mul2 #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .lhs(op_a), .rhs(mul_rhs), .prod(s1_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_op     <= OP_ADD;
      s1_simple <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op     <= op_idx;
        s1_simple <= simple_res;
      end
    end
  end

  assign prod_lo = s1_prod[W-1:0];
  assign prod_hi = s1_prod[2*W-1:W];

  always_comb begin
    unique case (s1_op)
      OP_MULL:         s2_pick = prod_lo;
      OP_MULH:         s2_pick = prod_hi;
      OP_ROTL, OP_ROTR: s2_pick = prod_lo | prod_hi;
      default:         s2_pick = s1_simple;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) result <= s2_pick;
    end
  end

  // R10
  issue_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  // R10
  s1_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  // R7
  rot_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && is_rot(s1_op)) |-> ((prod_lo & prod_hi) == '0));
endmodule

// File: tb/test_eleven_op_alu.sv
module test_eleven_op_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, sel = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        h_v [2];
  logic [31:0] h_e [2];
  string       h_t [2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  eleven_op_alu i_eleven_op_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .sel(sel),
    .out_valid(out_valid), .result(result)
  );

  function automatic int residue(logic [31:0] s);
    longint q;
    q = longint'(s) / 11;
    return int'(longint'(s) - q * 11);
  endfunction

  function automatic logic [31:0] rot_left(logic [31:0] v, int n);
    if (n == 0) return v;
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic int count_lead(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[31 - i]) return i;
    return 32;
  endfunction

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] s);
    logic [63:0] p;
    int n;
    p = {32'd0, a} * {32'd0, b};
    n = int'(b & 32'd31);
    case (residue(s))
      0: return a + b;
      1: return p[31:0];
      2: return p[63:32];
      3: return (a <= b) ? a : b;
      4: return rot_left(a, n);
      5: return rot_left(a, (32 - n) % 32);
      6: return a & b;
      7: return a | b;
      8: return a ^ b;
      9: return 32'(count_lead(a) + count_lead(b));
      default: return 32'($countones(a) + $countones(b));
    endcase
  endfunction

  function automatic string req_tag(logic [31:0] s);
    case (residue(s))
      0, 6, 7, 8: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // One cycle: check outputs due now, then drive the next issue (R10 ordering, R1 selection)
  task automatic step(logic v, logic [31:0] a, logic [31:0] b, logic [31:0] s);
    @(negedge clk);
    check_val("R10 out_valid", 32'(out_valid), 32'(h_v[1]));
    if (h_v[1]) check_val({h_t[1], " R1"}, result, h_e[1]);
    h_v[1] = h_v[0];
    h_e[1] = h_e[0];
    h_t[1] = h_t[0];
    h_v[0] = v;
    h_e[0] = model(a, b, s);
    h_t[0] = req_tag(s);
    in_valid = v;
    op_a = a;
    op_b = b;
    sel = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    h_v[0] = 1'b0; h_v[1] = 1'b0;
    h_e[0] = '0;   h_e[1] = '0;
    h_t[0] = "";   h_t[1] = "";
    void'($urandom(32'h5eed_0b11));
    repeat (3) @(negedge clk);
    // R11: outputs cleared while reset is held
    check_val("R11 valid in reset", 32'(out_valid), 32'd0);
    check_val("R11 result in reset", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R11 valid after reset", 32'(out_valid), 32'd0);
    check_val("R11 result after reset", result, 32'd0);

    // Directed corner cases
    step(1'b1, 32'h12345678, 32'd8, 32'd4);            // R6 example
    step(1'b1, 32'hDEADBEEF, 32'd0, 32'd15);           // R6 rotate by 0
    step(1'b1, 32'h80000001, 32'd31, 32'd4);           // R6 rotate by 31
    step(1'b1, 32'hCAFEF00D, 32'd32, 32'd26);          // R6 amount mod 32
    step(1'b1, 32'h12345678, 32'd8, 32'd5);            // R7
    step(1'b1, 32'h80000001, 32'd31, 32'd5);           // R7 rotate by 31
    step(1'b1, 32'hA5A5A5A5, 32'd0, 32'd16);           // R7 rotate by 0
    step(1'b1, 32'd0, 32'd0, 32'd9);                   // R8 zero operands -> 64
    step(1'b1, 32'h00010000, 32'hFFFFFFFF, 32'd20);    // R8
    step(1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd2);     // R4 all ones
    step(1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd1);     // R3 all ones
    step(1'b1, 32'hFFFFFFFF, 32'd1, 32'd0);            // R2 wrap
    step(1'b1, 32'h80000000, 32'h7FFFFFFF, 32'd3);     // R5 unsigned compare
    step(1'b1, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'd10);    // R9
    step(1'b1, 32'h1234, 32'h5678, 32'hFFFFFFFF);      // R1 top selector
    step(1'b1, 32'h1234, 32'h5678, 32'hFFFFFFFE);      // R1
    step(1'b0, 32'hFFFF, 32'hFFFF, 32'd0);             // R10 idle
    for (int r = 0; r < 11; r++)
      step(1'b1, 32'h9E3779B9, 32'h7F4A7C15, 32'(r + 11 * (r + 3)));

    // Seeded random traffic across all residues
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb, rs;
      ra = $urandom;
      rb = $urandom;
      rs = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 10)) : $urandom;
      if ($urandom_range(0, 7) == 0) rb = rb & 32'h1F;
      step($urandom_range(0, 4) != 0, ra, rb, rs);
    end
    step(1'b0, '0, '0, '0);
    step(1'b0, '0, '0, '0);
    step(1'b0, '0, '0, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule